// File: doc/BRIEF.md
# Filtered Quadrature Decoder Front End

This block is the input stage for one axis of an incremental encoder. It takes the raw phase A and phase B lines, an index line and a gate line. Each line is first synchronized into the filter clock domain. It then passes through a noise filter whose sample rate is set by a programmable 8-bit prescaler. The filtered levels are turned into one-cycle count-enable pulses, each with a direction bit, for a downstream position counter.

The decoder has three quadrature resolutions: one, two or four counts per encoder cycle. A fourth setting treats A as a count clock, B as a direction level and the gate line as a count qualifier. The block also produces a one-cycle index pulse. Noise seen on A or B, and phase transitions that are not legal, set a sticky error flag that stays set until it is cleared by a strobe.

The whole block runs on the filter clock. A write strobe loads the prescaler value and the decode mode together.

Top module: `quad_front_end`

## Requirements
- R1: The filter sampling tick occurs once every P+1 filter clocks, where P is the 8-bit prescale value. A configuration write loads P and the decode mode together, and restarts the prescaler.
- R2: A filtered input changes only after the same new value has been seen at two consecutive sampling ticks. A pulse seen at fewer than two ticks never produces a count or an index pulse.
- R3: When a new value is seen on A or B at one tick and not confirmed at the next tick, noiseErr is set. Noise on the index or gate lines does not set it, and clean encoder motion never sets it.
- R4: noiseErr stays at 1 until noiseClr is asserted. A new error event in the same cycle as noiseClr wins over the clear.
- R5: With cfgMode = 2'b01 (one count per cycle), exactly one count is produced per full quadrature cycle, on a rising edge of filtered A.
- R6: With cfgMode = 2'b10 (two counts per cycle), a count is produced on both the rising and the falling edge of filtered A.
- R7: With cfgMode = 2'b11 (four counts per cycle), a count is produced on every edge of A and every edge of B.
- R8: In the quadrature modes, countUp = 1 when A leads B (forward sequence AB = 00,10,11,01) and countUp = 0 for the reverse sequence.
- R9: With cfgMode = 2'b00, a count is produced on each rising edge of filtered A while filtered gate is 1, with countUp equal to the filtered B level. No count is produced while gate is 0.
- R10: In the quadrature modes, if A and B change at the same filtered sample, no count is produced and noiseErr is set.
- R11: idxPulse is high for exactly one cycle on each rising edge of filtered index, in every mode.
- R12: After reset, countEn, countUp, idxPulse and noiseErr are 0, the prescale value is 0 and the mode is four counts per cycle (2'b11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| filterClk | input | 1 | Filter clock; the only clock of the block |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe that loads cfgPrescale and cfgMode |
| cfgPrescale | input | 8 | Prescale value P; the sampling tick repeats every P+1 clocks |
| cfgMode | input | 2 | Decode mode: 00 count/direction/gate, 01 one count, 10 two counts, 11 four counts per cycle |
| noiseClr | input | 1 | Clears the sticky noise flag |
| encA | input | 1 | Raw phase A, or the count input in mode 00 |
| encB | input | 1 | Raw phase B, or the direction level in mode 00 |
| encIdx | input | 1 | Raw index input |
| encGate | input | 1 | Raw gate input that qualifies counting in mode 00 |
| countEn | output | 1 | One-cycle count pulse for the downstream counter |
| countUp | output | 1 | Direction of the count given with countEn (1 = up) |
| idxPulse | output | 1 | One-cycle pulse on the rising edge of filtered index |
| noiseErr | output | 1 | Sticky noise or illegal-transition flag |

## Verification
The hardest conditions to reach are a glitch that lands on exactly one sampling tick, and a transition on A and B that the filter admits at the same tick. Both depend on where the prescaler phase falls relative to the input edges. The bench reaches them by setting the prescale value to 0, so that every clock is a tick, and by driving glitches one clock wide or changing A and B on the same clock edge. With a larger prescale value, it brackets the acceptance boundary with pulses that are slightly shorter than one tick period, which can never be confirmed, and slightly longer than two tick periods, which must always be confirmed.

// File: rtl/qfe_pkg.sv
package qfe_pkg;

  typedef enum logic [1:0] {
    MODE_CNTDIR = 2'b00,
    MODE_X1     = 2'b01,
    MODE_X2     = 2'b10,
    MODE_X4     = 2'b11
  } decode_mode_e;

  // Strobes and mode handed from control to datapath
  typedef struct packed {
    logic         sampleTick;
    logic         clearNoise;
    decode_mode_e mode;
  } ctrl_strobe_t;

  localparam int NUM_CH  = 4;
  localparam int CH_A    = 0;
  localparam int CH_B    = 1;
  localparam int CH_IDX  = 2;
  localparam int CH_GATE = 3;

endpackage

// File: rtl/qfe_ctrl.sv
module qfe_ctrl
  import qfe_pkg::*;
#(
  parameter int PRESCALE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [PRESCALE_W-1:0] cfgPrescale,
  input  logic [1:0]            cfgMode,
  input  logic                  noiseClr,
  output ctrl_strobe_t          strobes
);

  logic [PRESCALE_W-1:0] prescaleReg;
  logic [PRESCALE_W-1:0] divCnt;
  decode_mode_e          modeReg;
  logic                  tick;

  assign tick = (divCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescaleReg <= '0;
      modeReg     <= MODE_X4;
      divCnt      <= '0;
    end else if (cfgWe) begin
      prescaleReg <= cfgPrescale;
      modeReg     <= decode_mode_e'(cfgMode);
      divCnt      <= '0;
    end else if (tick) begin
      divCnt <= prescaleReg;
    end else begin
      divCnt <= divCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.sampleTick = tick;
    strobes.clearNoise = noiseClr;
    strobes.mode       = modeReg;
  end

  // Checker: independent count of the gap between ticks
  logic [PRESCALE_W:0] gapCnt;
  logic                gapValid;

  always_ff @(posedge clk) begin
    if (!rstN || cfgWe) begin
      gapCnt   <= '0;
      gapValid <= 1'b0;
    end else if (tick) begin
      gapCnt   <= '0;
      gapValid <= 1'b1;
    end else begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rstN)
    (tick && gapValid && !cfgWe) |-> (gapCnt == {1'b0, prescaleReg}));

  assert_write_restarts_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> tick);

endmodule

// File: rtl/qfe_glitch_filter.sv
module qfe_glitch_filter (
  input  logic clk,
  input  logic rstN,
  input  logic sampleTick,
  input  logic din,
  output logic level,
  output logic noise
);

  logic lastSample;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSample <= 1'b0;
      level      <= 1'b0;
    end else if (sampleTick) begin
      lastSample <= din;
      if (din == lastSample) level <= din;
    end
  end

  // A candidate from the previous tick that this tick does not confirm
  assign noise = sampleTick && (lastSample != level) && (din != lastSample);

  assert_level_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> $stable(level));

endmodule

// File: rtl/qfe_datapath.sv
module qfe_datapath
  import qfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobes,
  input  logic         rawA,
  input  logic         rawB,
  input  logic         rawIdx,
  input  logic         rawGate,
  output logic         countEn,
  output logic         countUp,
  output logic         idxPulse,
  output logic         noiseErr
);

  logic [NUM_CH-1:0] rawVec;
  logic [NUM_CH-1:0] syncVec;
  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] chNoise;

  assign rawVec = {rawGate, rawIdx, rawB, rawA};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [SYNC_STAGES-1:0] syncSh;

    always_ff @(posedge clk) begin
      if (!rstN) syncSh <= '0;
      else       syncSh <= {syncSh[SYNC_STAGES-2:0], rawVec[ch]};
    end

    assign syncVec[ch] = syncSh[SYNC_STAGES-1];

    qfe_glitch_filter u_filter (
      .clk        (clk),
      .rstN       (rstN),
      .sampleTick (strobes.sampleTick),
      .din        (syncVec[ch]),
      .level      (lvl[ch]),
      .noise      (chNoise[ch])
    );
  end

  logic prevA, prevB, prevIdx;
  logic edgeA, edgeB, dualEdge;
  logic cntNext, upNext, setNoise;

  assign edgeA = lvl[CH_A] ^ prevA;
  assign edgeB = lvl[CH_B] ^ prevB;
  assign dualEdge = edgeA && edgeB && (strobes.mode != MODE_CNTDIR);

  always_comb begin
    cntNext = 1'b0;
    upNext  = lvl[CH_A] ^ prevB;
    unique case (strobes.mode)
      MODE_CNTDIR: begin
        cntNext = edgeA && lvl[CH_A] && lvl[CH_GATE];
        upNext  = lvl[CH_B];
      end
      MODE_X1: cntNext = edgeA && lvl[CH_A] && !edgeB;
      MODE_X2: cntNext = edgeA && !edgeB;
      MODE_X4: cntNext = edgeA ^ edgeB;
      default: cntNext = 1'b0;
    endcase
  end

  assign setNoise = chNoise[CH_A] || chNoise[CH_B] || dualEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA    <= 1'b0;
      prevB    <= 1'b0;
      prevIdx  <= 1'b0;
      countEn  <= 1'b0;
      countUp  <= 1'b0;
      idxPulse <= 1'b0;
      noiseErr <= 1'b0;
    end else begin
      prevA    <= lvl[CH_A];
      prevB    <= lvl[CH_B];
      prevIdx  <= lvl[CH_IDX];
      countEn  <= cntNext;
      countUp  <= cntNext ? upNext : countUp;
      idxPulse <= lvl[CH_IDX] && !prevIdx;
      if (setNoise)                noiseErr <= 1'b1;
      else if (strobes.clearNoise) noiseErr <= 1'b0;
    end
  end

  assert_noise_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (noiseErr && !strobes.clearNoise) |=> noiseErr);

  assert_noise_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chNoise[CH_A] || chNoise[CH_B]) |=> noiseErr);

  assert_dual_edge_no_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    dualEdge |=> (!countEn && noiseErr));

  assert_gate_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.mode == MODE_CNTDIR && !lvl[CH_GATE]) |=> !countEn);

  assert_index_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    idxPulse |=> !idxPulse);

endmodule

// File: rtl/quad_front_end.sv
module quad_front_end
  import qfe_pkg::*;
#(
  parameter int PRESCALE_W  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  filterClk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [PRESCALE_W-1:0] cfgPrescale,
  input  logic [1:0]            cfgMode,
  input  logic                  noiseClr,
  input  logic                  encA,
  input  logic                  encB,
  input  logic                  encIdx,
  input  logic                  encGate,
  output logic                  countEn,
  output logic                  countUp,
  output logic                  idxPulse,
  output logic                  noiseErr
);

  ctrl_strobe_t strobes;

  qfe_ctrl #(.PRESCALE_W(PRESCALE_W)) u_ctrl (
    .clk         (filterClk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgPrescale (cfgPrescale),
    .cfgMode     (cfgMode),
    .noiseClr    (noiseClr),
    .strobes     (strobes)
  );

  qfe_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk      (filterClk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rawA     (encA),
    .rawB     (encB),
    .rawIdx   (encIdx),
    .rawGate  (encGate),
    .countEn  (countEn),
    .countUp  (countUp),
    .idxPulse (idxPulse),
    .noiseErr (noiseErr)
  );

  assert_reset_quiet_R12: assert property (@(posedge filterClk)
    !rstN |=> (!countEn && !idxPulse && !noiseErr));

endmodule

// File: tb/quad_front_end_tb.sv
module quad_front_end_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  presc;
    logic [7:0]  cycles;
    logic        fwd;
    logic        gate;
    logic [15:0] expUp;
    logic [15:0] expDn;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'b01, 8'd0, 8'd5, 1'b1, 1'b1, 16'd5,  16'd0},
    '{2'b01, 8'd2, 8'd3, 1'b0, 1'b1, 16'd0,  16'd3},
    '{2'b10, 8'd1, 8'd4, 1'b1, 1'b1, 16'd8,  16'd0},
    '{2'b10, 8'd0, 8'd2, 1'b0, 1'b1, 16'd0,  16'd4},
    '{2'b11, 8'd3, 8'd3, 1'b1, 1'b1, 16'd12, 16'd0},
    '{2'b11, 8'd0, 8'd4, 1'b0, 1'b1, 16'd0,  16'd16},
    '{2'b00, 8'd1, 8'd6, 1'b1, 1'b1, 16'd6,  16'd0},
    '{2'b00, 8'd0, 8'd5, 1'b0, 1'b1, 16'd0,  16'd5},
    '{2'b00, 8'd2, 8'd4, 1'b1, 1'b0, 16'd0,  16'd0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgPrescale = '0;
  logic [1:0] cfgMode = '0;
  logic       noiseClr = 1'b0;
  logic       encA = 1'b0, encB = 1'b0, encIdx = 1'b0, encGate = 1'b0;
  logic       countEn, countUp, idxPulse, noiseErr;

  int checks = 0;
  int failures = 0;
  int upCnt = 0, dnCnt = 0, idxCnt = 0;
  int cycleCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_front_end dut_i (
    .filterClk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPrescale(cfgPrescale),
    .cfgMode(cfgMode), .noiseClr(noiseClr), .encA(encA), .encB(encB),
    .encIdx(encIdx), .encGate(encGate), .countEn(countEn), .countUp(countUp),
    .idxPulse(idxPulse), .noiseErr(noiseErr)
  );

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    cycleCnt++;
    if (rstN && countEn) begin
      if (countUp) upCnt++;
      else         dnCnt++;
    end
    if (rstN && idxPulse) idxCnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input logic [1:0] mode, input logic [7:0] p);
    @(negedge clk);
    cfgWe = 1'b1; cfgMode = mode; cfgPrescale = p;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk);
    noiseClr = 1'b1;
    @(negedge clk);
    noiseClr = 1'b0;
    idle(2);
  endtask

  task automatic runQuad(input int cycles, input bit fwd, input int hold);
    for (int c = 0; c < cycles; c++) begin
      if (fwd) begin
        encA = 1; encB = 0; idle(hold);
        encA = 1; encB = 1; idle(hold);
        encA = 0; encB = 1; idle(hold);
        encA = 0; encB = 0; idle(hold);
      end else begin
        encA = 0; encB = 1; idle(hold);
        encA = 1; encB = 1; idle(hold);
        encA = 1; encB = 0; idle(hold);
        encA = 0; encB = 0; idle(hold);
      end
    end
  endtask

  task automatic runPulses(input int cycles, input int hold);
    for (int c = 0; c < cycles; c++) begin
      encA = 1; idle(hold);
      encA = 0; idle(hold);
    end
  endtask

  // Watchdog
  initial begin
    while (!done && cycleCnt < 150000) @(negedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycleCnt);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int baseUp, baseDn, baseIdx, hold;
    idle(3);
    // R12: reset state
    check("R12 countEn after reset", countEn, 0);
    check("R12 idxPulse after reset", idxPulse, 0);
    check("R12 noiseErr after reset", noiseErr, 0);
    @(negedge clk); rstN = 1'b1;
    idle(4);
    // R12: default mode is four counts per cycle at prescale 0
    baseUp = upCnt; baseDn = dnCnt;
    runQuad(1, 1'b1, 3);
    idle(10);
    check("R12 default x4 up count", upCnt - baseUp, 4);
    check("R12 default x4 down count", dnCnt - baseDn, 0);

    // Vector table: R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      configure(VECS[v].mode, VECS[v].presc);
      hold = 3 * (int'(VECS[v].presc) + 1);
      if (VECS[v].mode == 2'b00) begin
        encGate = VECS[v].gate; encB = VECS[v].fwd;
        idle(2 * hold + 6);
      end
      baseUp = upCnt; baseDn = dnCnt;
      if (VECS[v].mode == 2'b00) runPulses(VECS[v].cycles, hold);
      else                       runQuad(VECS[v].cycles, VECS[v].fwd, hold);
      idle(2 * hold + 8);
      check($sformatf("R5/R6/R7/R8/R9 vec%0d up", v), upCnt - baseUp, VECS[v].expUp);
      check($sformatf("R5/R6/R7/R8/R9 vec%0d down", v), dnCnt - baseDn, VECS[v].expDn);
      encB = 1'b0; encGate = 1'b0;
      idle(2 * hold + 6);
    end
    check("R3 no noise on clean motion", noiseErr, 0);

    // R3: one-clock glitch on A at prescale 0
    configure(2'b11, 8'd0);
    idle(6);
    baseUp = upCnt; baseDn = dnCnt;
    encA = 1'b1; idle(1); encA = 1'b0;
    idle(10);
    check("R3 glitch sets noiseErr", noiseErr, 1);
    check("R2 glitch gives no count", (upCnt - baseUp) + (dnCnt - baseDn), 0);
    // R4: flag is sticky, then cleared
    idle(30);
    check("R4 noiseErr sticky", noiseErr, 1);
    clearFlag();
    check("R4 noiseErr cleared", noiseErr, 0);

    // R10: A and B change together
    baseUp = upCnt; baseDn = dnCnt;
    encA = 1'b1; encB = 1'b1; idle(8);
    check("R10 dual edge sets noiseErr", noiseErr, 1);
    encA = 1'b0; encB = 1'b0; idle(8);
    check("R10 dual edge gives no count", (upCnt - baseUp) + (dnCnt - baseDn), 0);
    clearFlag();

    // R1/R2: acceptance boundary at prescale 4 (tick every 5 clocks)
    configure(2'b11, 8'd4);
    idle(12);
    baseUp = upCnt; baseDn = dnCnt;
    encA = 1'b1; idle(4); encA = 1'b0;
    idle(30);
    check("R1 short pulse not accepted", (upCnt - baseUp) + (dnCnt - baseDn), 0);
    clearFlag();
    baseUp = upCnt; baseDn = dnCnt;
    encA = 1'b1; idle(11); encA = 1'b0;
    idle(30);
    check("R1 long pulse up count", upCnt - baseUp, 1);
    check("R1 long pulse down count", dnCnt - baseDn, 1);
    clearFlag();

    // R11: index pulse, and index glitch ignored
    configure(2'b01, 8'd0);
    idle(6);
    baseIdx = idxCnt;
    encIdx = 1'b1; idle(6); encIdx = 1'b0; idle(8);
    check("R11 one index pulse", idxCnt - baseIdx, 1);
    baseIdx = idxCnt;
    encIdx = 1'b1; idle(1); encIdx = 1'b0; idle(8);
    check("R11 index glitch gives no pulse", idxCnt - baseIdx, 0);
    check("R3 index glitch leaves noiseErr", noiseErr, 0);

    // R4: noise event during clear wins over the clear
    configure(2'b11, 8'd0);
    idle(6);
    encA = 1'b1; idle(1); encA = 1'b0;
    // Glitch seen at sample k, noise at k+1; sync adds 2 clocks
    idle(2);
    noiseClr = 1'b1; idle(1); noiseClr = 1'b0;
    idle(4);
    check("R4 set wins over clear", noiseErr, 1);
    clearFlag();
    check("R4 clear after set", noiseErr, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule